// File: doc/BRIEF.md
# X/Y Key Matrix Burst Scan Sequencer

This block produces the drive timing for a charge-transfer key matrix with 8 X drive lines and 4 Y sample gates. It visits the 32 keys one after another. For each key it first holds the charge integrator in reset. It then fires a burst of X pulses on the key's X line. The number of pulses is the key's gain. The key's Y sample gate opens shortly before each rising X edge and closes shortly after it. The Y lines that are not in use stay connected to ground. When the burst is over, the same X pins carry the key's 8-bit offset code, which feeds an external resistor ladder. After a settling delay the block pulses an ADC sample strobe.

Two coarse-cancel outputs are active during the burst window according to the key's 2-bit coarse code. A shortened-dwell copy of the Y gates is also available. It closes the gate a fixed number of clocks after the X line rises, which limits the charge that a surface water film can return. The key configuration (gain, offset, coarse code) is supplied by the surrounding logic as a function of the key index. It is captured while the integrator is in reset.

Top module: `xy_burst_scanner`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the outputs are as follows: x_drv is 0, y_gate is 0, y_sw is 0, y_gnd is all ones, int_rst is 1, adc_strobe is 0 and key_idx is 0.
- R2: Keys are visited in the order key_idx = 0,1,...,31, then 0 again, where key_idx = 8*y + x (x is 0..7, y is 0..3). Each key ends with a single-cycle adc_strobe that comes together with key_done. The key_idx shown at that moment is the key whose sample is being taken.
- R3: During a key's burst, x_drv carries exactly G pulses, where G is the gain value captured for that key. Every pulse is on bit x = key_idx mod 8 only. A gain of 0 produces no pulse.
- R4: During a burst, y_gate has only bit y = key_idx / 8 set. That bit is high for YSU_CYC cycles before each rising X edge and for YHD_CYC cycles starting at that edge.
- R5: A y_gnd bit is never high in the same cycle as its y_gate bit. A y_gnd bit is never high in the cycle right after its y_gate bit was high. Unselected Y lines stay grounded throughout.
- R6: After the burst, and after DEAD_CYC cycles with both X and Y quiet, x_drv holds the key's offset code for SETTLE_CYC cycles. It keeps holding that code through the adc_strobe cycle.
- R7: int_rst is high for RST_CYC cycles between two keys. It is never high while an X pulse, the offset code or a Y gate is present.
- R8: While the selected Y line is released from ground (the burst window), the outputs follow the coarse code c: cz[0] = (c != 0) and cz[1] = (c == 3). Outside the burst window cz is 0.
- R9: With short_dwell_en low, y_sw equals y_gate. With short_dwell_en high, y_sw = y_gate AND NOT(OR of x_drv delayed by DWELL_DLY cycles). With the default parameters this leaves the gate open for 1 cycle of each X high time instead of 2.
- R10: The time between the strobes of two consecutive keys is RST_CYC + 2*DEAD_CYC + G*(YSU_CYC+XH_CYC+XL_CYC) + SETTLE_CYC + 1 cycles. G is the gain of the later key. With the defaults this is 14 + 9*G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_dwell_en | input | 1 | Selects the shortened-dwell gate on y_sw |
| key_gain | input | GAIN_W | Burst length of the key at key_idx |
| key_offset | input | NX | Offset code of the key at key_idx |
| key_coarse | input | 2 | Coarse cancel code of the key at key_idx |
| x_drv | output | NX | X drive pulses, or the offset code after the burst |
| y_gate | output | NY | Y sample-switch gates, active high |
| y_gnd | output | NY | Y grounding-switch controls, active high |
| y_sw | output | NY | Y gate after optional dwell shortening |
| cz | output | 2 | Coarse cancel stage enables |
| int_rst | output | 1 | Integrator reset |
| adc_strobe | output | 1 | ADC sample strobe |
| key_done | output | 1 | End-of-key pulse |
| key_idx | output | $clog2(NX*NY) | Index of the key being scanned |

## Verification
The assertions assume a parameter set that keeps the timing meaningful. YSU_CYC, DEAD_CYC, XH_CYC and SETTLE_CYC are all at least 1. YHD_CYC is no larger than XH_CYC. XL_CYC is at least DWELL_DLY, so the delayed X copy has cleared before the next gate opens. They also assume that key_gain, key_offset and key_coarse are valid while int_rst is high, and that short_dwell_en changes only between keys. The stimulus derives the key configuration combinationally from key_idx, so it is stable for the whole key. It toggles the dwell mode only right after a strobe, during the reset phase of the next key.

// File: rtl/xyb_pkg.sv
package xyb_pkg;

  typedef enum logic [2:0] {
    PH_RST,
    PH_GUARD_IN,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_GUARD_OUT,
    PH_SETTLE,
    PH_SAMPLE
  } xyb_phase_e;

  // coarse code -> cancel stage enables; stage 2 only together with stage 1
  function automatic logic [1:0] cancel_map(input logic [1:0] code);
    logic [1:0] en;
    en[0] = (code != 2'd0);
    en[1] = (code == 2'd3);
    return en;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // strobe-to-strobe spacing for a key of gain g
  function automatic int key_period(input int rst_c, input int dead_c, input int su_c,
                                    input int xh_c, input int xl_c, input int settle_c,
                                    input int g);
    return rst_c + 2 * dead_c + g * (su_c + xh_c + xl_c) + settle_c + 1;
  endfunction

endpackage

// File: rtl/xyb_key_ptr.sv
module xyb_key_ptr #(
  parameter int NX = 8,
  parameter int NY = 4,
  localparam int XW = $clog2(NX),
  localparam int YW = $clog2(NY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [XW+YW-1:0]   key_idx,
  output logic [NX-1:0]      x_sel,
  output logic [NY-1:0]      y_sel
);

  logic [XW-1:0] x_cnt;
  logic [YW-1:0] y_cnt;
  logic          x_wrap;

  assign x_wrap = (x_cnt == XW'(NX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_cnt <= '0;
      y_cnt <= '0;
    end else if (advance) begin
      x_cnt <= x_wrap ? '0 : x_cnt + 1'b1;
      if (x_wrap) y_cnt <= (y_cnt == YW'(NY - 1)) ? '0 : y_cnt + 1'b1;
    end
  end

  assign key_idx = {y_cnt, x_cnt};

  for (genvar i = 0; i < NX; i++) begin : g_xdec
    assign x_sel[i] = (x_cnt == XW'(i));
  end
  for (genvar j = 0; j < NY; j++) begin : g_ydec
    assign y_sel[j] = (y_cnt == YW'(j));
  end

endmodule

// File: rtl/xyb_burst_fsm.sv
module xyb_burst_fsm
  import xyb_pkg::*;
#(
  parameter int GAIN_W     = 8,
  parameter int RST_CYC    = 3,
  parameter int DEAD_CYC   = 1,
  parameter int YSU_CYC    = 1,
  parameter int XH_CYC     = 4,
  parameter int XL_CYC     = 4,
  parameter int YHD_CYC    = 2,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] gain,
  output xyb_phase_e        phase,
  output logic              gate_on,
  output logic              x_on,
  output logic              burst_win,
  output logic              offset_on,
  output logic              int_rst,
  output logic              sample,
  output logic              pulse_end
);

  localparam int MAXD = max2(max2(max2(RST_CYC, DEAD_CYC), max2(YSU_CYC, XH_CYC)),
                             max2(max2(XL_CYC, SETTLE_CYC), YHD_CYC));
  localparam int TW   = $clog2(MAXD + 1);

  logic [TW-1:0]     cnt;
  logic [GAIN_W-1:0] pcnt;
  logic              last;
  xyb_phase_e        nxt;

  function automatic logic [TW-1:0] last_cnt(input xyb_phase_e p);
    case (p)
      PH_RST:       return TW'(RST_CYC - 1);
      PH_GUARD_IN:  return TW'(DEAD_CYC - 1);
      PH_SETUP:     return TW'(YSU_CYC - 1);
      PH_HIGH:      return TW'(XH_CYC - 1);
      PH_LOW:       return TW'(XL_CYC - 1);
      PH_GUARD_OUT: return TW'(DEAD_CYC - 1);
      PH_SETTLE:    return TW'(SETTLE_CYC - 1);
      default:      return '0;
    endcase
  endfunction

  assign last      = (cnt == last_cnt(phase));
  assign pulse_end = (phase == PH_LOW) && last;

  always_comb begin
    case (phase)
      PH_RST:       nxt = PH_GUARD_IN;
      PH_GUARD_IN:  nxt = (gain == '0) ? PH_GUARD_OUT : PH_SETUP;
      PH_SETUP:     nxt = PH_HIGH;
      PH_HIGH:      nxt = PH_LOW;
      PH_LOW:       nxt = (pcnt + 1'b1 == gain) ? PH_GUARD_OUT : PH_SETUP;
      PH_GUARD_OUT: nxt = PH_SETTLE;
      PH_SETTLE:    nxt = PH_SAMPLE;
      default:      nxt = PH_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RST;
      cnt   <= '0;
      pcnt  <= '0;
    end else if (last) begin
      phase <= nxt;
      cnt   <= '0;
      if (phase == PH_GUARD_IN) pcnt <= '0;
      else if (pulse_end)       pcnt <= pcnt + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign x_on      = (phase == PH_HIGH);
  assign gate_on   = (phase == PH_SETUP) || (x_on && (cnt < TW'(YHD_CYC)));
  assign burst_win = (phase inside {PH_GUARD_IN, PH_SETUP, PH_HIGH, PH_LOW, PH_GUARD_OUT});
  assign offset_on = (phase == PH_SETTLE) || (phase == PH_SAMPLE);
  assign int_rst   = (phase == PH_RST);
  assign sample    = (phase == PH_SAMPLE);

endmodule

// File: rtl/xyb_dwell_gate.sv
module xyb_dwell_gate #(
  parameter int NX  = 8,
  parameter int NY  = 4,
  parameter int DLY = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          short_en,
  input  logic [NX-1:0] x_drv,
  input  logic [NY-1:0] y_gate,
  output logic [NY-1:0] y_sw
);

  logic [DLY:0] tap;
  logic         x_late;

  assign tap[0] = |x_drv;

  for (genvar i = 0; i < DLY; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[i+1] <= 1'b0;
      else        tap[i+1] <= tap[i];
    end
  end

  assign x_late = tap[DLY];
  assign y_sw   = short_en ? (y_gate & ~{NY{x_late}}) : y_gate;

endmodule

// File: rtl/xy_burst_scanner.sv
module xy_burst_scanner
  import xyb_pkg::*;
#(
  parameter int NX         = 8,
  parameter int NY         = 4,
  parameter int GAIN_W     = 8,
  parameter int RST_CYC    = 3,
  parameter int DEAD_CYC   = 1,
  parameter int YSU_CYC    = 1,
  parameter int XH_CYC     = 4,
  parameter int XL_CYC     = 4,
  parameter int YHD_CYC    = 2,
  parameter int SETTLE_CYC = 8,
  parameter int DWELL_DLY  = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       short_dwell_en,
  input  logic [GAIN_W-1:0]          key_gain,
  input  logic [NX-1:0]              key_offset,
  input  logic [1:0]                 key_coarse,
  output logic [NX-1:0]              x_drv,
  output logic [NY-1:0]              y_gate,
  output logic [NY-1:0]              y_gnd,
  output logic [NY-1:0]              y_sw,
  output logic [1:0]                 cz,
  output logic                       int_rst,
  output logic                       adc_strobe,
  output logic                       key_done,
  output logic [$clog2(NX*NY)-1:0]   key_idx
);

  xyb_phase_e        phase;
  logic              gate_on, x_on, burst_win, offset_on, sample, pulse_end, rst_ph;
  logic [NX-1:0]     x_sel;
  logic [NY-1:0]     y_sel;
  logic [GAIN_W-1:0] gain_q;
  logic [NX-1:0]     offset_q;
  logic [1:0]        coarse_q;

  // configuration is captured while the integrator is held in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q   <= '0;
      offset_q <= '0;
      coarse_q <= '0;
    end else if (rst_ph) begin
      gain_q   <= key_gain;
      offset_q <= key_offset;
      coarse_q <= key_coarse;
    end
  end

  xyb_key_ptr #(.NX(NX), .NY(NY)) ptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (sample),
    .key_idx (key_idx),
    .x_sel   (x_sel),
    .y_sel   (y_sel)
  );

  xyb_burst_fsm #(
    .GAIN_W(GAIN_W), .RST_CYC(RST_CYC), .DEAD_CYC(DEAD_CYC), .YSU_CYC(YSU_CYC),
    .XH_CYC(XH_CYC), .XL_CYC(XL_CYC), .YHD_CYC(YHD_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gain      (gain_q),
    .phase     (phase),
    .gate_on   (gate_on),
    .x_on      (x_on),
    .burst_win (burst_win),
    .offset_on (offset_on),
    .int_rst   (rst_ph),
    .sample    (sample),
    .pulse_end (pulse_end)
  );

  always_comb begin
    if (x_on)           x_drv = x_sel;
    else if (offset_on) x_drv = offset_q;
    else                x_drv = '0;
  end

  assign y_gate     = gate_on ? y_sel : '0;
  assign y_gnd      = burst_win ? ~y_sel : '1;
  assign cz         = burst_win ? cancel_map(coarse_q) : 2'b00;
  assign int_rst    = rst_ph;
  assign adc_strobe = sample;
  assign key_done   = sample;

  xyb_dwell_gate #(.NX(NX), .NY(NY), .DLY(DWELL_DLY)) dwell_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .short_en (short_dwell_en),
    .x_drv    (x_drv),
    .y_gate   (y_gate),
    .y_sw     (y_sw)
  );

endmodule

// File: rtl/xyb_scan_chk.sv
module xyb_scan_chk #(
  parameter int NX = 8,
  parameter int NY = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NX-1:0] x_drv,
  input logic [NY-1:0] y_gate,
  input logic [NY-1:0] y_gnd,
  input logic [NY-1:0] y_sw,
  input logic [1:0]    cz,
  input logic          int_rst,
  input logic          adc_strobe
);

  // R5
  gnd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_gate & y_gnd) == '0);

  // R5
  gnd_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_gnd & $past(y_gate)) == '0);

  // R4
  y_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(y_gate));

  // R3
  x_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|y_gate) |-> $onehot0(x_drv));

  // R4
  y_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|x_drv) && (|y_gate)) |-> $past(|y_gate));

  // R7
  irst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> (x_drv == '0 && y_gate == '0 && !adc_strobe));

  // R8
  cz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst || adc_strobe) |-> (cz == 2'b00));

  // R9
  dwell_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_sw & ~y_gate) == '0);

  // R6
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> $stable(x_drv));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |=> !adc_strobe);

endmodule

bind xy_burst_scanner xyb_scan_chk #(.NX(NX), .NY(NY)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .x_drv      (x_drv),
  .y_gate     (y_gate),
  .y_gnd      (y_gnd),
  .y_sw       (y_sw),
  .cz         (cz),
  .int_rst    (int_rst),
  .adc_strobe (adc_strobe)
);

// File: tb/xy_burst_scanner_tb_top.sv
module xy_burst_scanner_tb_top;

  localparam int NX = 8, NY = 4, GW = 8;
  localparam int T_RST = 3, T_DEAD = 1, T_SU = 1, T_XH = 4, T_XL = 4, T_HD = 2, T_SET = 8, T_DW = 1;

  // vector table: {gain, offset, coarse, expected cz}
  localparam logic [19:0] CFG [8] = '{
    {8'd3, 8'hA5, 2'd0, 2'b00},
    {8'd0, 8'h00, 2'd1, 2'b01},
    {8'd1, 8'hFF, 2'd3, 2'b11},
    {8'd5, 8'h3C, 2'd2, 2'b01},
    {8'd2, 8'h81, 2'd3, 2'b11},
    {8'd7, 8'h01, 2'd1, 2'b01},
    {8'd4, 8'h7E, 2'd0, 2'b00},
    {8'd6, 8'h80, 2'd3, 2'b11}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          short_dwell_en = 1'b0;
  logic [GW-1:0] key_gain;
  logic [NX-1:0] key_offset;
  logic [1:0]    key_coarse;
  logic [NX-1:0] x_drv;
  logic [NY-1:0] y_gate, y_gnd, y_sw;
  logic [1:0]    cz;
  logic          int_rst, adc_strobe, key_done;
  logic [4:0]    key_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [19:0] cfg_of(input int k);
    return CFG[(k + k / 8) % 8];
  endfunction

  always_comb begin
    key_gain   = cfg_of(int'(key_idx))[19:12];
    key_offset = cfg_of(int'(key_idx))[11:4];
    key_coarse = cfg_of(int'(key_idx))[3:2];
  end

  xy_burst_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .short_dwell_en(short_dwell_en),
    .key_gain(key_gain), .key_offset(key_offset), .key_coarse(key_coarse),
    .x_drv(x_drv), .y_gate(y_gate), .y_gnd(y_gnd), .y_sw(y_sw), .cz(cz),
    .int_rst(int_rst), .adc_strobe(adc_strobe), .key_done(key_done), .key_idx(key_idx)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk(x_drv == '0,          {tag, " x_drv"},   x_drv, 0);
    chk(y_gate == '0,         {tag, " y_gate"},  y_gate, 0);
    chk(y_sw == '0,           {tag, " y_sw"},    y_sw, 0);
    chk(y_gnd == '1,          {tag, " y_gnd"},   y_gnd, 15);
    chk(int_rst == 1'b1,      {tag, " int_rst"}, int_rst, 1);
    chk(adc_strobe == 1'b0,   {tag, " strobe"},  adc_strobe, 0);
    chk(key_idx == '0,        {tag, " key_idx"}, key_idx, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [NX-1:0] px;
    logic [NY-1:0] py;
    int cyc, last_strobe, pulses, wrong_x, bad_setup, bad_y, bad_gnd, bad_cz, bad_irst, overlap;
    px = '0; py = '0;
    cyc = 0; last_strobe = -1;
    pulses = 0; wrong_x = 0; bad_setup = 0; bad_y = 0; bad_gnd = 0; bad_cz = 0; bad_irst = 0; overlap = 0;

    // R1: reset state while held and just after release
    repeat (3) @(negedge clk);
    chk_reset_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 after release");
    px = x_drv; py = y_gate;

    // main loop over the vector table: two sweeps, normal then short dwell
    for (int sw = 0; sw < 2; sw++) begin
      for (int k = 0; k < NX * NY; k++) begin
        logic [19:0] e;
        int g, ydx, xdx;
        e = cfg_of(k);
        g = int'(e[19:12]);
        xdx = k % NX;
        ydx = k / NX;
        while (1) begin
          @(negedge clk);
          cyc++;
          if ((|x_drv) && !(|px) && (|y_gate)) begin
            pulses++;
            if (x_drv != NX'(1 << xdx)) wrong_x++;
            if (py != NY'(1 << ydx)) bad_setup++;
          end
          if ((|y_gate) && y_gate != NY'(1 << ydx)) bad_y++;
          if ((|y_gate) && y_gnd != ~NY'(1 << ydx)) bad_gnd++;
          if ((y_gnd & y_gate) != '0 || (y_gnd & py) != '0) bad_gnd++;
          if ((|y_gate) && cz != e[1:0]) bad_cz++;
          if ((int_rst || adc_strobe) && cz != 2'b00) bad_cz++;
          if (int_rst && ((|x_drv) || (|y_gate))) bad_irst++;
          if ((|x_drv) && (|y_gate) && (y_sw == y_gate)) overlap++;
          if (sw == 0 && y_sw != y_gate) bad_y++;
          px = x_drv; py = y_gate;
          if (adc_strobe) break;
        end
        chk(key_idx == 5'(k),  "R2 key order", key_idx, k);
        chk(key_done == 1'b1,  "R2 key_done with strobe", key_done, 1);
        chk(pulses == g,       "R3 pulse count", pulses, g);
        chk(wrong_x == 0,      "R3 pulse on wrong X line", wrong_x, 0);
        chk(bad_setup == 0 && bad_y == 0, "R4 Y gate select/setup", bad_setup + bad_y, 0);
        chk(bad_gnd == 0,      "R5 grounding and dead time", bad_gnd, 0);
        chk(x_drv == e[11:4],  "R6 offset at strobe", x_drv, e[11:4]);
        chk(bad_irst == 0,     "R7 int_rst quiet", bad_irst, 0);
        chk(bad_cz == 0,       "R8 coarse cancel map", bad_cz, 0);
        chk(overlap == g * (sw == 0 ? T_HD : T_DW), "R9 gate overlap with X", overlap,
            g * (sw == 0 ? T_HD : T_DW));
        if (last_strobe >= 0)
          chk(cyc - last_strobe == T_RST + 2 * T_DEAD + g * (T_SU + T_XH + T_XL) + T_SET + 1,
              "R10 key period", cyc - last_strobe,
              T_RST + 2 * T_DEAD + g * (T_SU + T_XH + T_XL) + T_SET + 1);
        last_strobe = cyc;
        pulses = 0; wrong_x = 0; bad_setup = 0; bad_y = 0; bad_gnd = 0; bad_cz = 0; bad_irst = 0; overlap = 0;
        if (sw == 0 && k == NX * NY - 1) short_dwell_en = 1'b1;
      end
    end

    // R2: index wraps to 0 after the last key
    @(negedge clk);
    chk(key_idx == '0 && int_rst, "R2 wrap to key 0", key_idx, 0);

    // R1: reset in the middle of a burst
    short_dwell_en = 1'b0;
    while (!(|y_gate)) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_reset_state("R1 mid-burst reset");
    rst_n = 1'b1;
    while (!adc_strobe) @(negedge clk);
    chk(key_idx == '0, "R2 restart at key 0", key_idx, 0);
    chk(x_drv == cfg_of(0)[11:4], "R6 offset after restart", x_drv, cfg_of(0)[11:4]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule